// File: doc/BRIEF.md
# Three-Port Controller I/O Register Bank

This block is a byte-wide register file that a host processor reaches over a four-bit offset bus. It serves three controller ports. Each port has seven pins: two handshake lines, one strobe line and four data lines. The processor sets the pin output levels and the output enables through the block. It also reads back a mix of the latched output values and the live pin levels.

Each port has five registers: a data latch, a direction register, a transmit buffer, a serial-control register and an unused slot. Offset 0 holds a read-only version byte. That byte is built from the region code, a boot-ROM-present flag and an expansion-absent flag. A port's pin outputs are refreshed, and an update strobe is pulsed, on every data write. On a direction write, this happens only when the new value differs from the stored one. There is no serial engine, so the three serial status flags always read as zero.

Top module: `ctrl_io_bank`

## Requirements
- R1: After reset, the data latches, direction registers, serial-control registers, pin outputs and update strobes are all zero. The transmit buffers of ports A and B (offsets 0x7, 0xA) read 0xFF, and that of port C (offset 0xD) reads 0xFB.
- R2: A read of a data offset (0x1, 0x2, 0x3 for ports A, B, C) returns, for bits 6..0, the latch bit where the direction bit is 1 and the pin input where it is 0.
- R3: Bit 7 of a data read always returns the bit 7 last written to that latch, whatever the direction register holds.
- R4: In the cycle after a data write, that port's out_level equals the written bits 6..0. Its out_en equals the direction bits 6..0, and its update strobe is high for exactly one cycle.
- R5: A direction write (offsets 0x4, 0x5, 0x6) whose value differs from the stored byte sets out_en to its bits 6..0 in the next cycle and pulses the update strobe. A write of an equal value causes no pulse and no output change. Without a write, out_en holds.
- R6: A transmit-buffer write (offsets 0x7, 0xA, 0xD) stores the whole byte, and a read returns it.
- R7: A serial-control write (offsets 0x9, 0xC, 0xF) stores only bits 7..3. Bits 2..0 always read as 0.
- R8: Offset 0 reads VERSION = REGION_CODE | EXP_ABSENT<<5 | BOOT_ROM. Writes to offsets 0x0, 0x8, 0xB and 0xE are ignored, and the last three read 0.
- R9: rdata_o is 0 whenever rd_en_i is low.
- R10: A write to one port's register leaves the other ports' registers and pin outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | 8 | Combinational read data |
| pin_in_i | input | 21 | Pin input levels, port p at bits [7p+6:7p] |
| out_level_o | output | 21 | Pin output levels, same packing |
| out_en_o | output | 21 | Pin output enables, same packing |
| upd_o | output | 3 | One-cycle port update strobe, one bit per port |

## Verification
Random write streams over all sixteen offsets, with random pin levels on every read, exercise the data-read merge under many direction masks. A wrong mask polarity or a bit 7 that follows the pins shows up here. Directed rewrites of an unchanged direction value separate the change-only forwarding from unconditional forwarding. Writes of all ones to serial-control, version and unused offsets expose missing masks and missing write protection. Reads with the enable low confirm the idle zero.

// File: rtl/ctrl_io_pkg.sv
package ctrl_io_pkg;
  localparam int NPORT = 3;
  localparam int PIN_W = 7;
  localparam int AW    = 4;

  function automatic logic [AW-1:0] off_data(int p);
    return AW'(1 + p);
  endfunction
  function automatic logic [AW-1:0] off_dir(int p);
    return AW'(4 + p);
  endfunction
  function automatic logic [AW-1:0] off_tx(int p);
    return AW'(7 + 3 * p);
  endfunction
  function automatic logic [AW-1:0] off_sctl(int p);
    return AW'(9 + 3 * p);
  endfunction
  function automatic logic [7:0] tx_rst(int p);
    return (p == 2) ? 8'hFB : 8'hFF;
  endfunction
endpackage

// File: rtl/ctrl_io_port.sv
module ctrl_io_port #(
  parameter int         PIN_W  = 7,
  parameter logic [7:0] TX_RST = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_data_i,
  input  logic             wr_dir_i,
  input  logic             wr_tx_i,
  input  logic             wr_sctl_i,
  input  logic [7:0]       wdata_i,
  input  logic [PIN_W-1:0] pin_in_i,
  output logic [7:0]       data_rd_o,
  output logic [7:0]       dir_o,
  output logic [7:0]       tx_o,
  output logic [7:0]       sctl_o,
  output logic [PIN_W-1:0] out_level_o,
  output logic [PIN_W-1:0] out_en_o,
  output logic             upd_o
);
  localparam int SCTL_W = 5;

  logic [7:0]        latch_q, dir_q, tx_q;
  logic [SCTL_W-1:0] sctl_q;
  logic [7:0]        mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q     <= '0;
      dir_q       <= '0;
      tx_q        <= TX_RST;
      sctl_q      <= '0;
      out_level_o <= '0;
      out_en_o    <= '0;
      upd_o       <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (wr_data_i) begin
        latch_q     <= wdata_i;
        out_level_o <= wdata_i[PIN_W-1:0];
        out_en_o    <= dir_q[PIN_W-1:0];
        upd_o       <= 1'b1;
      end
      // forward direction only on change
      if (wr_dir_i && (wdata_i != dir_q)) begin
        dir_q       <= wdata_i;
        out_level_o <= latch_q[PIN_W-1:0];
        out_en_o    <= wdata_i[PIN_W-1:0];
        upd_o       <= 1'b1;
      end
      if (wr_tx_i)   tx_q   <= wdata_i;
      if (wr_sctl_i) sctl_q <= wdata_i[7:8-SCTL_W];
    end
  end

  assign mask      = {1'b1, dir_q[PIN_W-1:0]};
  assign data_rd_o = (latch_q & mask) | ({1'b0, pin_in_i} & ~mask);
  assign dir_o     = dir_q;
  assign tx_o      = tx_q;
  assign sctl_o    = {sctl_q, 3'b000};
endmodule

// File: rtl/ctrl_io_bank.sv
module ctrl_io_bank
  import ctrl_io_pkg::*;
#(
  parameter logic [7:0] REGION_CODE = 8'h80,
  parameter logic       BOOT_ROM    = 1'b0,
  parameter logic       EXP_ABSENT  = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_en_i,
  input  logic [7:0]             wdata_i,
  input  logic                   rd_en_i,
  output logic [7:0]             rdata_o,
  input  logic [NPORT*PIN_W-1:0] pin_in_i,
  output logic [NPORT*PIN_W-1:0] out_level_o,
  output logic [NPORT*PIN_W-1:0] out_en_o,
  output logic [NPORT-1:0]       upd_o
);
  localparam logic [7:0] VERSION = REGION_CODE | {2'b00, EXP_ABSENT, 4'b0000, BOOT_ROM};

  logic [7:0] data_rd [NPORT];
  logic [7:0] dir_rd  [NPORT];
  logic [7:0] tx_rd   [NPORT];
  logic [7:0] sctl_rd [NPORT];
  logic [7:0] rd_val;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ctrl_io_port #(
      .PIN_W  (PIN_W),
      .TX_RST (tx_rst(p))
    ) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_data_i   (wr_en_i && addr_i == off_data(p)),
      .wr_dir_i    (wr_en_i && addr_i == off_dir(p)),
      .wr_tx_i     (wr_en_i && addr_i == off_tx(p)),
      .wr_sctl_i   (wr_en_i && addr_i == off_sctl(p)),
      .wdata_i     (wdata_i),
      .pin_in_i    (pin_in_i[p*PIN_W +: PIN_W]),
      .data_rd_o   (data_rd[p]),
      .dir_o       (dir_rd[p]),
      .tx_o        (tx_rd[p]),
      .sctl_o      (sctl_rd[p]),
      .out_level_o (out_level_o[p*PIN_W +: PIN_W]),
      .out_en_o    (out_en_o[p*PIN_W +: PIN_W]),
      .upd_o       (upd_o[p])
    );
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == '0) rd_val = VERSION;
    for (int p = 0; p < NPORT; p++) begin
      if (addr_i == off_data(p)) rd_val = data_rd[p];
      if (addr_i == off_dir(p))  rd_val = dir_rd[p];
      if (addr_i == off_tx(p))   rd_val = tx_rd[p];
      if (addr_i == off_sctl(p)) rd_val = sctl_rd[p];
    end
  end

  assign rdata_o = rd_en_i ? rd_val : 8'h00;
endmodule

// File: rtl/ctrl_io_bank_chk.sv
module ctrl_io_bank_chk
  import ctrl_io_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h00
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [AW-1:0]          addr_i,
  input logic                   wr_en_i,
  input logic [7:0]             wdata_i,
  input logic                   rd_en_i,
  input logic [7:0]             rdata_o,
  input logic [NPORT*PIN_W-1:0] out_level_o,
  input logic [NPORT*PIN_W-1:0] out_en_o,
  input logic [NPORT-1:0]       upd_o
);
  p_rd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 8'h00);

  p_version_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 4'h0) |-> rdata_o == VERSION);

  p_oe_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(out_en_o));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    p_upd_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o[p] |-> $past(wr_en_i && (addr_i == off_data(p) || addr_i == off_dir(p))));

    p_data_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_en_i && addr_i == off_data(p)) |-> upd_o[p]);

    p_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_en_i && addr_i == off_data(p))
        |-> out_level_o[p*PIN_W +: PIN_W] == $past(wdata_i[PIN_W-1:0]));

    p_sctl_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == off_sctl(p)) |-> rdata_o[2:0] == 3'b000);
  end
endmodule

bind ctrl_io_bank ctrl_io_bank_chk #(.VERSION(VERSION)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rd_en_i     (rd_en_i),
  .rdata_o     (rdata_o),
  .out_level_o (out_level_o),
  .out_en_o    (out_en_o),
  .upd_o       (upd_o)
);

// File: tb/ctrl_io_bank_test.sv
module ctrl_io_bank_test;
  localparam int NP = 3;
  localparam int W  = 7;
  localparam logic [7:0] VER = 8'hA0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    rdata;
  logic [NP*W-1:0] pin_in = '0;
  logic [NP*W-1:0] out_level, out_en;
  logic [NP-1:0] upd;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_latch [NP];
  logic [7:0] m_dir   [NP];
  logic [7:0] m_tx    [NP];
  logic [7:0] m_sctl  [NP];
  logic [6:0] m_lvl   [NP];
  logic [6:0] m_oe    [NP];
  logic [NP-1:0] m_upd;

  ctrl_io_bank #(.REGION_CODE(8'h80), .BOOT_ROM(1'b0), .EXP_ABSENT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .pin_in_i(pin_in),
    .out_level_o(out_level), .out_en_o(out_en), .upd_o(upd)
  );

  always #5 clk = ~clk;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [NP*W-1:0] pins);
    logic [7:0] r = 8'h00;
    if (a == 0) r = VER;
    for (int p = 0; p < NP; p++) begin
      logic [7:0] mk = {1'b1, m_dir[p][6:0]};
      if (a == 4'(1 + p)) r = (m_latch[p] & mk) | ({1'b0, pins[p*W +: W]} & ~mk);
      if (a == 4'(4 + p)) r = m_dir[p];
      if (a == 4'(7 + 3*p)) r = m_tx[p];
      if (a == 4'(9 + 3*p)) r = m_sctl[p];
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_latch[p] = 0; m_dir[p] = 0; m_sctl[p] = 0;
      m_tx[p] = (p == 2) ? 8'hFB : 8'hFF;
      m_lvl[p] = 0; m_oe[p] = 0;
    end
    m_upd = '0;
  endtask

  task automatic check_outs(input string tag);
    for (int p = 0; p < NP; p++) begin
      check(out_level[p*W +: W] == m_lvl[p], {tag, " level"}, 32'(out_level[p*W +: W]), 32'(m_lvl[p]));
      check(out_en[p*W +: W] == m_oe[p], {tag, " enable"}, 32'(out_en[p*W +: W]), 32'(m_oe[p]));
    end
    check(upd == m_upd, {tag, " strobe"}, 32'(upd), 32'(m_upd));
  endtask

  // write, then check outputs one cycle later (R4 R5 R10)
  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    m_upd = '0;
    for (int p = 0; p < NP; p++) begin
      if (a == 4'(1 + p)) begin
        m_latch[p] = d; m_lvl[p] = d[6:0]; m_oe[p] = m_dir[p][6:0]; m_upd[p] = 1'b1;
      end
      if (a == 4'(4 + p) && d != m_dir[p]) begin
        m_dir[p] = d; m_lvl[p] = m_latch[p][6:0]; m_oe[p] = d[6:0]; m_upd[p] = 1'b1;
      end
      if (a == 4'(7 + 3*p)) m_tx[p] = d;
      if (a == 4'(9 + 3*p)) m_sctl[p] = d & 8'hF8;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check_outs("R4/R5/R10 after write");
  endtask

  task automatic do_read(input logic [3:0] a, input logic [NP*W-1:0] pins, input string tag);
    addr = a; rd_en = 1'b1; pin_in = pins;
    #1;
    check(rdata == exp_read(a, pins), tag, 32'(rdata), 32'(exp_read(a, pins)));
    rd_en = 1'b0;
  endtask

  initial begin
    logic [NP*W-1:0] pins;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_outs("R1 reset outputs");
    for (int a = 0; a < 16; a++) do_read(4'(a), '1, "R1 reset readback");

    // R9 idle read
    addr = 4'h7; rd_en = 1'b0; #1;
    check(rdata == 8'h00, "R9 idle rdata", 32'(rdata), 0);

    // R2 R3 directed
    do_write(4'h4, 8'h0F);
    do_write(4'h1, 8'hA5);
    do_read(4'h1, {NP{7'h70}}, "R2 merge port A");
    do_write(4'h4, 8'h00);
    do_read(4'h1, {NP{7'h00}}, "R3 bit7 echo all-input");
    do_write(4'h2, 8'h80);
    do_read(4'h2, {NP{7'h7F}}, "R3 bit7 echo port B");

    // R5 same-value direction write: no strobe, outputs held
    do_write(4'h5, 8'h33);
    do_write(4'h5, 8'h33);
    check(upd == 3'b000, "R5 equal dir write no strobe", 32'(upd), 0);

    // R6 R7 R8
    do_write(4'hD, 8'h3C);
    do_read(4'hD, '0, "R6 tx buffer C");
    do_write(4'hC, 8'hFF);
    do_read(4'hC, '0, "R7 serial ctrl mask");
    do_write(4'h0, 8'h5A);
    do_read(4'h0, '0, "R8 version ignores write");
    do_write(4'hB, 8'hFF);
    do_read(4'hB, '0, "R8 unused offset stays 0");

    // random mix (R2 R5 R6 R7 R10)
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 9) < 2 && a >= 4 && a <= 6) d = m_dir[a-4];
      if ($urandom_range(0, 9) < 7) do_write(a, d);
      pins = NP*W'($urandom);
      do_read(4'($urandom_range(0, 15)), pins, "R2/R6/R7 random readback");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule